// File: doc/BRIEF.md
# Reloadable Up/Down Interval Timer

This block is a single interval timer that sits on a Wishbone-style slave bus. Software sets the run, single-shot and direction controls, programs a span value and may preload the running count at any time. While it runs, the count moves by one on every clock, either toward zero or toward the span. When it reaches its end point, the block latches an interrupt request.

After the end point, the timer does one of two things. In repeating operation it restarts from the opposite end on the next clock. In single-shot operation it drops its run control and parks on the end value. The interrupt request stays raised until software writes the control register. The external reset is asserted asynchronously and released through a two-stage synchronizer. The register file, the count engine and the bus port are separate submodules.

Top module: `span_timer`

## Requirements
- R1: After reset, the control, span and count registers all read zero and `irq_o` is low.
- R2: An access is taken on the clock edge where `wb_cyc_i` and `wb_stb_i` are high and `wb_ack_o` is low. `wb_ack_o` is high for exactly the following cycle. Read data in that cycle shows the register contents from before the taking edge.
- R3: Register offsets (byte address) are: control at 0x0, span at 0x4 and count at 0x8. Control bit 0 is run, bit 1 is single-shot (1) or repeating (0), bit 2 is up (1) or down (0), and bit 3 reads the interrupt flag (read-only). Any other address, including a misaligned one, reads zero and ignores writes.
- R4: While run is clear, the count holds its value.
- R5: Counting down, the count drops by one per clock. A clock edge with run set and count equal to zero is a terminal event.
- R6: Counting up, the count rises by one per clock. A clock edge with run set and count equal to the span is a terminal event.
- R7: On a terminal event in repeating operation, the count is loaded on that edge with the span (down) or with zero (up).
- R8: On a terminal event in single-shot operation, run clears and the count stays at the terminal value. Setting run again while the count still sits there gives a new terminal event on the next edge.
- R9: A terminal event sets the interrupt flag, which drives `irq_o` and stays set. Any control write clears it, except on an edge that also has a terminal event: there the flag stays set.
- R10: A bus write to the count register on the same edge as a count update or reload wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable (1 write, 0 read) |
| wb_adr_i | input | ADR_W (8) | Byte address |
| wb_dat_i | input | DAT_W (32) | Write data |
| wb_dat_o | output | DAT_W (32) | Read data, valid while `wb_ack_o` is high |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest situation to reach from the ports is a bus write that lands on the exact edge of a terminal event. This covers a control write that tries to clear the flag while the flag is being set, and a count preload that competes with a reload. The stimulus reaches it because every access takes exactly two clocks from the previous one. Idle cycles are added so that the taking edge of the write falls on the edge where a preloaded count reaches zero or the span. The scoreboard then reads back the count value and the interrupt pin at fixed cycle offsets from the enabling write.

// File: rtl/span_timer_pkg.sv
package span_timer_pkg;

  // register slot selected by the word address
  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_SPAN  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;

  // control field bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SHOT_BIT = 1;
  localparam int CTRL_UP_BIT   = 2;
  localparam int CTRL_FLAG_BIT = 3;
  localparam int CTRL_W        = 3;

  typedef struct packed {
    logic up;
    logic shot;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/span_timer_rst_sync.sv
module span_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/span_timer_bus_port.sv
module span_timer_bus_port
  import span_timer_pkg::*;
#(
  parameter int ADR_W = 8,
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  input  ctrl_t            ctrl,
  input  logic             flag,
  input  logic [DAT_W-1:0] span,
  input  logic [DAT_W-1:0] count,
  output logic             ack,
  output logic [DAT_W-1:0] rdat,
  output logic             wr_ctrl,
  output logic             wr_span,
  output logic             wr_count
);

  localparam int WORD_LSB = 2;
  localparam int SLOT_MSB = WORD_LSB + 1;

  logic             take;
  logic             ack_d;
  logic             addr_ok;
  slot_e            slot;
  logic [DAT_W-1:0] ctrl_word;
  logic [DAT_W-1:0] rdat_d;
  logic             rdat_en;

  // taken once per access; the pending ack blocks a second take
  assign take  = cyc && stb && !ack;
  assign ack_d = take;

  // mapped only when the high bits and the byte lane bits are zero
  always_comb begin
    addr_ok = ((adr >> (SLOT_MSB + 1)) == '0) && (adr[WORD_LSB-1:0] == '0);
    if (!addr_ok) slot = SLOT_NONE;
    else          slot = slot_e'(adr[SLOT_MSB:WORD_LSB]);
  end

  assign wr_ctrl  = take && we && (slot == SLOT_CTRL);
  assign wr_span  = take && we && (slot == SLOT_SPAN);
  assign wr_count = take && we && (slot == SLOT_COUNT);

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_RUN_BIT]  = ctrl.run;
    ctrl_word[CTRL_SHOT_BIT] = ctrl.shot;
    ctrl_word[CTRL_UP_BIT]   = ctrl.up;
    ctrl_word[CTRL_FLAG_BIT] = flag;
  end

  always_comb begin
    unique case (slot)
      SLOT_CTRL:  rdat_d = ctrl_word;
      SLOT_SPAN:  rdat_d = span;
      SLOT_COUNT: rdat_d = count;
      default:    rdat_d = '0;
    endcase
  end

  assign rdat_en = take && !we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat <= '0;
    else if (rdat_en) rdat <= rdat_d;
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);  // R2
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cyc && stb));  // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !we && (slot == SLOT_NONE)) |=> (rdat == '0));  // R3

endmodule

// File: rtl/span_timer_regs.sv
module span_timer_regs
  import span_timer_pkg::*;
#(
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_span,
  input  ctrl_t            ctrl_wdat,
  input  logic [DAT_W-1:0] span_wdat,
  input  logic             hit,
  output ctrl_t            ctrl,
  output logic [DAT_W-1:0] span,
  output logic             flag
);

  ctrl_t ctrl_d;
  logic  ctrl_en;
  logic  flag_d;

  // bus write wins for all fields; otherwise a single-shot end drops run
  always_comb begin
    ctrl_d  = ctrl;
    ctrl_en = 1'b0;
    if (wr_ctrl) begin
      ctrl_d  = ctrl_wdat;
      ctrl_en = 1'b1;
    end else if (hit && ctrl.shot) begin
      ctrl_d.run = 1'b0;
      ctrl_en    = 1'b1;
    end
  end

  // a terminal event outranks a clearing write
  always_comb begin
    if (hit)          flag_d = 1'b1;
    else if (wr_ctrl) flag_d = 1'b0;
    else              flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_en) ctrl <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       span <= '0;
    else if (wr_span) span <= span_wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_ctrl) |=> flag);  // R9
  AST_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.shot && !wr_ctrl) |=> !ctrl.run);  // R8

endmodule

// File: rtl/span_timer_core.sv
module span_timer_core
  import span_timer_pkg::*;
#(
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [DAT_W-1:0] span,
  input  logic             wr_count,
  input  logic [DAT_W-1:0] count_wdat,
  output logic [DAT_W-1:0] count,
  output logic             hit
);

  localparam logic [DAT_W-1:0] STEP = {{(DAT_W-1){1'b0}}, 1'b1};

  logic [DAT_W-1:0] term;
  logic [DAT_W-1:0] restart;
  logic [DAT_W-1:0] stepped;
  logic [DAT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    term    = ctrl.up ? span : '0;
    restart = ctrl.up ? '0 : span;
    stepped = ctrl.up ? (count + STEP) : (count - STEP);
    hit     = ctrl.run && (count == term);
  end

  always_comb begin
    count_d  = count;
    count_en = 1'b0;
    if (wr_count) begin
      count_d  = count_wdat;
      count_en = 1'b1;
    end else if (ctrl.run) begin
      count_en = 1'b1;
      if (hit) count_d = ctrl.shot ? count : restart;
      else     count_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_count) |=> $stable(count));  // R4
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.up && (count != '0) && !wr_count) |=> (count == $past(count) - STEP));  // R5
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && ctrl.up && (count != span) && !wr_count) |=> (count == $past(count) + STEP));  // R6
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl.shot && !ctrl.up && !wr_count) |=> (count == $past(span)));  // R7
  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl.shot && ctrl.up && !wr_count) |=> (count == '0));  // R7
  AST_SHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.shot && !wr_count) |=> $stable(count));  // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count == $past(count_wdat)));  // R10

endmodule

// File: rtl/span_timer.sv
module span_timer
  import span_timer_pkg::*;
#(
  parameter int ADR_W = 8,
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [DAT_W-1:0] wb_dat_i,
  output logic [DAT_W-1:0] wb_dat_o,
  output logic             wb_ack_o,
  output logic             irq_o
);

  logic             rst_n_s;
  logic             wr_ctrl;
  logic             wr_span;
  logic             wr_count;
  logic             hit;
  logic             flag;
  ctrl_t            ctrl;
  ctrl_t            ctrl_wdat;
  logic [DAT_W-1:0] span;
  logic [DAT_W-1:0] count;

  assign ctrl_wdat = ctrl_t'(wb_dat_i[CTRL_W-1:0]);

  span_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  span_timer_bus_port #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cyc      (wb_cyc_i),
    .stb      (wb_stb_i),
    .we       (wb_we_i),
    .adr      (wb_adr_i),
    .ctrl     (ctrl),
    .flag     (flag),
    .span     (span),
    .count    (count),
    .ack      (wb_ack_o),
    .rdat     (wb_dat_o),
    .wr_ctrl  (wr_ctrl),
    .wr_span  (wr_span),
    .wr_count (wr_count)
  );

  span_timer_regs #(.DAT_W(DAT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_ctrl   (wr_ctrl),
    .wr_span   (wr_span),
    .ctrl_wdat (ctrl_wdat),
    .span_wdat (wb_dat_i),
    .hit       (hit),
    .ctrl      (ctrl),
    .span      (span),
    .flag      (flag)
  );

  span_timer_core #(.DAT_W(DAT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ctrl       (ctrl),
    .span       (span),
    .wr_count   (wr_count),
    .count_wdat (wb_dat_i),
    .count      (count),
    .hit        (hit)
  );

  assign irq_o = flag;

endmodule

// File: tb/span_timer_test.sv
module span_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc, stb, we;
  logic [7:0]  adr;
  logic [31:0] wdat;
  logic [31:0] rdat;
  logic        ack;
  logic        irq;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 1'b0;
  bit ack_prev = 1'b0;

  typedef struct {
    bit          rd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_SPAN = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h08;

  always #10 clk = ~clk;

  span_timer uut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .irq_o(irq)
  );

  // monitor: pops one expected item per acknowledge
  always @(negedge clk) begin
    if (ack) begin
      if (ack_prev) begin
        miscmp++;
        $display("FAIL R2 ack width: got 2+ cycles expected 1");
      end
      if (sbq.size() == 0) begin
        miscmp++;
        $display("FAIL R2 stray ack: got 1 expected 0");
      end else begin
        item_t it;
        it = sbq.pop_front();
        vectors++;
        if (it.rd && rdat !== it.exp) begin
          miscmp++;
          $display("FAIL %s: got %h expected %h", it.tag, rdat, it.exp);
        end
      end
    end
    ack_prev <= ack;
  end

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    sbq.push_back('{rd: !w, exp: exp, tag: tag});
    @(negedge clk);
    vectors++;
    if (ack !== 1'b1) begin
      miscmp++;
      $display("FAIL R2 ack missing (%s): got %b expected 1", tag, ack);
    end
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    access(1'b1, a, d, 32'h0, "write");
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    vectors++;
    if (irq !== exp) begin
      miscmp++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_SPAN, 32'h0, "R1 span");
    rd(A_CNT,  32'h0, "R1 count");

    // R3 unmapped and misaligned addresses
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0007);
    wr(8'h05, 32'h0000_00AA);
    rd(8'h0C, 32'h0, "R3 unmapped 0xC");
    rd(8'h10, 32'h0, "R3 unmapped 0x10");
    rd(8'h09, 32'h0, "R3 misaligned");
    rd(A_CTRL, 32'h0, "R3 ctrl untouched");
    rd(A_SPAN, 32'h0, "R3 span untouched");
    rd(A_CNT,  32'h0, "R3 count untouched");
    wr(A_SPAN, 32'd7);
    rd(A_SPAN, 32'd7, "R3 span readback");

    // R4 hold while stopped
    wr(A_CNT, 32'd5);
    idle(3);
    rd(A_CNT, 32'd5, "R4 hold");

    // R5/R7 down, repeating: span 3, preload 2, run at edge Ec
    wr(A_SPAN, 32'd3);
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h1);                    // Ec
    rd(A_CNT, 32'd1, "R5 down step");     // Ec+2
    chk_irq(1'b0, "R5 before zero");
    idle(1);
    chk_irq(1'b1, "R9 set at zero");       // Ec+3.5
    rd(A_CNT, 32'd2, "R7 down reload");   // Ec+5
    idle(1);
    wr(A_CTRL, 32'h0);                    // Ec+8: stop, clear flag
    chk_irq(1'b0, "R9 cleared");
    rd(A_CNT, 32'd2, "R4 hold after stop");

    // R6/R8 up, single-shot: span 4, preload 1
    wr(A_SPAN, 32'd4);
    wr(A_CNT, 32'd1);
    wr(A_CTRL, 32'h7);                    // Ec
    rd(A_CTRL, 32'h7, "R3 ctrl fields");  // Ec+2
    idle(2);
    chk_irq(1'b1, "R6 up reaches span");   // Ec+4.5
    rd(A_CTRL, 32'hE, "R8 run cleared");  // Ec+6
    rd(A_CNT, 32'd4, "R8 parked");        // Ec+8
    idle(5);
    chk_irq(1'b1, "R9 sticky");
    rd(A_CNT, 32'd4, "R8 still parked");
    wr(A_CTRL, 32'h7);                    // Ec2: rearm at terminal
    chk_irq(1'b0, "R9 cleared by rearm");
    idle(1);
    chk_irq(1'b1, "R8 refire");            // Ec2+1.5
    rd(A_CNT, 32'd4, "R8 parked again");
    rd(A_CTRL, 32'hE, "R8 run cleared again");

    // R7/R10 up, repeating: span 2, preload 0
    wr(A_SPAN, 32'd2);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h5);                    // Ec
    chk_irq(1'b0, "R9 cleared by ctrl write");
    rd(A_CNT, 32'd1, "R6 up step");       // Ec+2
    rd(A_CNT, 32'd0, "R7 up reload zero");// Ec+4
    chk_irq(1'b1, "R9 up terminal");
    wr(A_CNT, 32'd9);                     // Ec+6, same edge as a terminal
    rd(A_CNT, 32'd10, "R10 write wins");  // Ec+8
    wr(A_CTRL, 32'h0);                    // Ec+10
    chk_irq(1'b0, "R9 cleared");
    rd(A_CNT, 32'd13, "R4 stopped count");

    // R9 set wins over clear on the same edge
    wr(A_SPAN, 32'd5);
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h1);                    // Ec
    idle(1);
    wr(A_CTRL, 32'h1);                    // Ec+3, terminal edge
    chk_irq(1'b1, "R9 set beats clear");
    rd(A_CNT, 32'd4, "R7 reload after coincidence");
    wr(A_CTRL, 32'h0);                    // Ec+7
    chk_irq(1'b0, "R9 cleared later");
    rd(A_CNT, 32'd1, "R4 final hold");

    idle(2);
    vectors++;
    if (sbq.size() != 0) begin
      miscmp++;
      $display("FAIL R2 pending: got %0d expected 0", sbq.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule